// File: doc/BRIEF.md
# Adaptive Dead-Time Half-Bridge Controller

This controller converts a single PWM command bit into two gate-enable outputs, one for the upper switch and one for the lower switch of a synchronous buck stage. It does not time the gap between the two switches with a counter. Each turn-on waits for sensed feedback instead. The upper output may rise only after the lower gate is seen low. The lower output may rise only after the switch node is seen low. The gap therefore follows the actual switching speed of the power stage, whatever its load, supply or temperature.

Several control inputs sit above the normal command path. An active-low clamp input forces the lower switch on and the upper switch off, whatever the other inputs are doing. A global enable turns both outputs off. A mode input removes the lower switch from service, which gives diode-rectified operation. A static polarity input decides whether the command is read directly or inverted.

Every input goes through a synchronizer before the controller uses it. If an awaited feedback edge does not arrive within a programmable number of cycles, a watchdog leaves both outputs off and sets a sticky fault flag. Only a low enable clears that flag.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: While `crowbar_ni` is low, `ls_o` is 1 and `hs_o` is 0 within SYNC_STAGES+1 cycles, whatever the values of enable, mode, command and fault.
- R2: While `crowbar_ni` is high and `en_i` is low, both `hs_o` and `ls_o` are 0.
- R3: While `crowbar_ni` is high and `sync_i` is low, `ls_o` stays 0. The upper output still follows the command.
- R4: `hs_o` rises only if the synchronized `ls_fb_i` (lower gate sensed, 1 = high) read 0 at the edge that set it.
- R5: Outside a clamp, `ls_o` rises only if the synchronized `sw_fb_i` (switch node sensed, 1 = high) read 0 at the edge that set it.
- R6: The upper switch is requested when `cmd_i ^ invert_i` is 1: `invert_i`=0 makes a high command select the upper switch, and `invert_i`=1 makes a low command select it. Once the command and feedback have settled with enable, mode and clamp inactive, `hs_o` equals the request and `ls_o` equals its complement.
- R7: `hs_o` and `ls_o` are never both 1 in the same cycle, including when the clamp is asserted and when it is released.
- R8: If the awaited feedback has not gone low after TIMEOUT_CYC cycles in a wait state, both outputs drop to 0 and `fault_o` becomes 1.
- R9: `fault_o` stays at 1, and both outputs stay off outside a clamp, until a low `en_i` has been synchronized. A low `en_i` clears `fault_o`.
- R10: While `rst_ni` is low, `hs_o`, `ls_o` and `fault_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 1 | PWM command bit |
| invert_i | input | 1 | Static command polarity: 1 means inverted |
| en_i | input | 1 | Global enable; when low, both outputs are off and the fault is cleared |
| sync_i | input | 1 | 1 = synchronous rectification; 0 = lower switch kept off |
| crowbar_ni | input | 1 | Clamp request, active low; forces the lower switch on |
| ls_fb_i | input | 1 | Sensed lower gate level, 1 = high |
| sw_fb_i | input | 1 | Sensed switch-node level, 1 = high |
| hs_o | output | 1 | Upper switch gate enable |
| ls_o | output | 1 | Lower switch gate enable |
| fault_o | output | 1 | Sticky feedback-timeout flag |

## Verification
The bench builds the block with two synchronizer stages and a timeout of 10 cycles.

The plant model returns each gate as feedback three cycles late, so a normal handover waits only about four cycles. A short limit lets a feedback line that is held high run the watchdog out within a few dozen cycles, which brings the fault, its stickiness and its clearing into reach.

With two stages, the bench can predict the edge at which each interlock decision was made. It checks every rising output against the feedback level present at that edge.

// File: rtl/hb_pkg.sv
`timescale 1ns/1ps
package hb_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT_LS,
    ST_HS_ON,
    ST_WAIT_SW,
    ST_LS_ON,
    ST_CLAMP
  } hb_state_e;

  localparam int unsigned IN_W    = 6;
  localparam int unsigned IX_CMD  = 0;
  localparam int unsigned IX_EN   = 1;
  localparam int unsigned IX_SYNC = 2;
  localparam int unsigned IX_CB   = 3;
  localparam int unsigned IX_LSFB = 4;
  localparam int unsigned IX_SWFB = 5;
  // clamp request idles high (inactive)
  localparam logic [IN_W-1:0] IN_RST = 6'b001000;
endpackage

// File: rtl/hb_sync.sv
`timescale 1ns/1ps
module hb_sync #(
  parameter int unsigned    W       = 1,
  parameter int unsigned    STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] src;
    if (g == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = stg_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= RST_VAL;
      else         stg_q[g] <= src;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hb_timeout.sv
`timescale 1ns/1ps
module hb_timeout #(
  parameter int unsigned LIMIT = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic exp_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign exp_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (run_i && !exp_o) cnt_q <= cnt_q + 1'b1;
  end

  a_r8_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  a_r8_cnt_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/hb_deadtime_ctrl.sv
`timescale 1ns/1ps
module hb_deadtime_ctrl
  import hb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TIMEOUT_CYC = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_i,
  input  logic invert_i,
  input  logic en_i,
  input  logic sync_i,
  input  logic crowbar_ni,
  input  logic ls_fb_i,
  input  logic sw_fb_i,
  output logic hs_o,
  output logic ls_o,
  output logic fault_o
);
  logic [IN_W-1:0] raw, syn;
  logic cmd_s, en_s, sync_s, cb_s, ls_fb_s, sw_fb_s;
  logic want_hs, waiting, tmr_exp, set_fault;
  logic hs_q, ls_q, fault_q;
  hb_state_e st_q, st_d;

  assign raw[IX_CMD]  = cmd_i;
  assign raw[IX_EN]   = en_i;
  assign raw[IX_SYNC] = sync_i;
  assign raw[IX_CB]   = crowbar_ni;
  assign raw[IX_LSFB] = ls_fb_i;
  assign raw[IX_SWFB] = sw_fb_i;

  hb_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign cmd_s   = syn[IX_CMD];
  assign en_s    = syn[IX_EN];
  assign sync_s  = syn[IX_SYNC];
  assign cb_s    = syn[IX_CB];
  assign ls_fb_s = syn[IX_LSFB];
  assign sw_fb_s = syn[IX_SWFB];

  // polarity is static; applied after the synchronizer
  assign want_hs = cmd_s ^ invert_i;
  assign waiting = (st_q == ST_WAIT_LS) || (st_q == ST_WAIT_SW);

  hb_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (waiting),
    .clr_i (st_d != st_q),
    .exp_o (tmr_exp)
  );

  always_comb begin
    st_d      = st_q;
    set_fault = 1'b0;
    if (!cb_s) begin
      st_d = ST_CLAMP;
    end else if (!en_s || fault_q) begin
      st_d = ST_OFF;
    end else begin
      unique case (st_q)
        ST_OFF: begin
          if (want_hs)     st_d = ST_WAIT_LS;
          else if (sync_s) st_d = ST_WAIT_SW;
        end
        ST_WAIT_LS: begin
          if (!want_hs)      st_d = ST_OFF;
          else if (!ls_fb_s) st_d = ST_HS_ON;
          else if (tmr_exp) begin
            st_d      = ST_OFF;
            set_fault = 1'b1;
          end
        end
        ST_HS_ON: if (!want_hs) st_d = ST_OFF;
        ST_WAIT_SW: begin
          if (want_hs || !sync_s) st_d = ST_OFF;
          else if (!sw_fb_s)      st_d = ST_LS_ON;
          else if (tmr_exp) begin
            st_d      = ST_OFF;
            set_fault = 1'b1;
          end
        end
        ST_LS_ON: if (want_hs || !sync_s) st_d = ST_OFF;
        // leaving the clamp always passes through a both-off cycle
        ST_CLAMP: st_d = ST_OFF;
        default:  st_d = ST_OFF;
      endcase
    end
  end

  // dedicated output flops keep the gate enables glitch-free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_OFF;
      hs_q    <= 1'b0;
      ls_q    <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      hs_q    <= (st_d == ST_HS_ON);
      ls_q    <= (st_d == ST_LS_ON) || (st_d == ST_CLAMP);
      fault_q <= en_s && (fault_q || set_fault);
    end
  end

  assign hs_o    = hs_q;
  assign ls_o    = ls_q;
  assign fault_o = fault_q;

  a_r1_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cb_s |=> ls_o && !hs_o);
  a_r2_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cb_s && !en_s |=> !hs_o && !ls_o);
  a_r3_nonsync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cb_s && !sync_s |=> !ls_o);
  a_r4_hs_interlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_o) |-> $past(!ls_fb_s));
  a_r5_ls_interlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_o) && $past(cb_s) |-> $past(!sw_fb_s));
  a_r7_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_o && ls_o));
  a_r8_fault_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && cb_s |=> !hs_o && !ls_o);
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && en_s |=> fault_o);
  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_s |=> !fault_o);
endmodule

// File: tb/sim_hb_deadtime_ctrl.sv
`timescale 1ns/1ps
module sim_hb_deadtime_ctrl;
  localparam int unsigned STG = 2;
  localparam int unsigned TMO = 10;
  localparam int unsigned PD  = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_i = 1'b0, invert_i = 1'b0, en_i = 1'b0, sync_i = 1'b0, crowbar_ni = 1'b1;
  logic ls_fb_i = 1'b0, sw_fb_i = 1'b0;
  logic hs_o, ls_o, fault_o;

  int errors = 0;
  int checks = 0;
  logic stuck_ls = 1'b0;
  logic mon_on = 1'b0;
  logic [PD-1:0] ls_pipe = '0, sw_pipe = '0;
  logic [7:0] lfh = '0, sfh = '0, cbh = '1;
  logic hs_prev = 1'b0, ls_prev = 1'b0;

  always #2 clk = ~clk;

  hb_deadtime_ctrl #(.SYNC_STAGES(STG), .TIMEOUT_CYC(TMO)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd_i), .invert_i(invert_i),
    .en_i(en_i), .sync_i(sync_i), .crowbar_ni(crowbar_ni),
    .ls_fb_i(ls_fb_i), .sw_fb_i(sw_fb_i),
    .hs_o(hs_o), .ls_o(ls_o), .fault_o(fault_o)
  );

  function automatic logic [1:0] exp_pair(logic cb, logic en, logic sy, logic cmd, logic inv);
    logic req;
    req = cmd ^ inv;
    if (!cb)      return 2'b01;
    else if (!en) return 2'b00;
    else if (req) return 2'b10;
    else if (sy)  return 2'b01;
    else          return 2'b00;
  endfunction

  task automatic chk(string tag, logic [2:0] got, logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: {hs,ls,fault} got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic apply(logic cb, logic en, logic sy, logic cmd, logic inv);
    @(posedge clk);
    #1;
    crowbar_ni = cb; en_i = en; sync_i = sy; cmd_i = cmd; invert_i = inv;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  // plant model plus per-cycle interlock checks
  always @(negedge clk) begin
    if (mon_on) begin
      checks++;
      if (hs_o && ls_o) begin
        errors++;
        $display("FAIL R7: hs=%b ls=%b expected not both 1", hs_o, ls_o);
      end
      if (hs_o && !hs_prev) begin
        checks++;
        if (lfh[STG] !== 1'b0) begin
          errors++;
          $display("FAIL R4: hs rose with lower feedback %b expected 0", lfh[STG]);
        end
      end
      if (ls_o && !ls_prev && crowbar_ni && (&cbh[4:0])) begin
        checks++;
        if (sfh[STG] !== 1'b0) begin
          errors++;
          $display("FAIL R5: ls rose with switch feedback %b expected 0", sfh[STG]);
        end
      end
    end
    hs_prev = hs_o;
    ls_prev = ls_o;
    ls_pipe = {ls_pipe[PD-2:0], ls_o};
    sw_pipe = {sw_pipe[PD-2:0], hs_o};
    ls_fb_i = stuck_ls | ls_pipe[PD-1];
    sw_fb_i = sw_pipe[PD-1];
    lfh = {lfh[6:0], ls_fb_i};
    sfh = {sfh[6:0], sw_fb_i};
    cbh = {cbh[6:0], crowbar_ni};
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    repeat (4) @(negedge clk);
    chk("R10 reset", {hs_o, ls_o, fault_o}, 3'b000);
    @(posedge clk); #1 rst_ni = 1'b1;
    mon_on = 1'b1;

    // directed cases
    apply(1, 1, 1, 0, 0); settle(24);
    chk("R6 low cmd selects lower", {hs_o, ls_o, fault_o}, 3'b010);
    apply(1, 1, 1, 1, 0); settle(24);
    chk("R6 high cmd selects upper", {hs_o, ls_o, fault_o}, 3'b100);
    apply(1, 1, 1, 1, 1); settle(24);
    chk("R6 inverted high cmd selects lower", {hs_o, ls_o, fault_o}, 3'b010);
    apply(1, 1, 1, 0, 1); settle(24);
    chk("R6 inverted low cmd selects upper", {hs_o, ls_o, fault_o}, 3'b100);
    apply(0, 1, 1, 0, 1); settle(STG + 2);
    chk("R1 clamp from upper on", {hs_o, ls_o, fault_o}, 3'b010);
    apply(0, 0, 0, 1, 0); settle(24);
    chk("R1 clamp with enable and mode low", {hs_o, ls_o, fault_o}, 3'b010);
    apply(1, 0, 1, 1, 0); settle(24);
    chk("R2 disabled both off", {hs_o, ls_o, fault_o}, 3'b000);
    apply(1, 1, 0, 0, 0); settle(24);
    chk("R3 nonsync lower stays off", {hs_o, ls_o, fault_o}, 3'b000);
    apply(1, 1, 0, 1, 0); settle(24);
    chk("R3 nonsync upper follows", {hs_o, ls_o, fault_o}, 3'b100);

    // timeout on a lower-gate feedback that never falls
    apply(1, 1, 1, 0, 0); settle(24);
    stuck_ls = 1'b1;
    apply(1, 1, 1, 1, 0); settle(12 + TMO + 8);
    chk("R8 timeout leaves both off", {hs_o, ls_o, fault_o}, 3'b001);
    stuck_ls = 1'b0; settle(24);
    chk("R9 fault sticky after recovery", {hs_o, ls_o, fault_o}, 3'b001);
    apply(1, 0, 1, 1, 0); settle(8);
    chk("R9 fault cleared by enable low", {hs_o, ls_o, fault_o}, 3'b000);
    apply(1, 1, 1, 1, 0); settle(24);
    chk("R9 normal after clear", {hs_o, ls_o, fault_o}, 3'b100);

    // constrained random
    for (int v = 0; v < 150; v++) begin
      logic cb, en, sy, cmd, inv;
      logic [1:0] e;
      string tag;
      cb  = ($urandom % 100) >= 8;
      en  = ($urandom % 100) < 85;
      sy  = ($urandom % 100) < 75;
      cmd = 1'($urandom % 2);
      inv = 1'($urandom % 2);
      apply(cb, en, sy, cmd, inv);
      settle(24);
      e = exp_pair(cb, en, sy, cmd, inv);
      if (!cb)              tag = "R1 random";
      else if (!en)         tag = "R2 random";
      else if (!(cmd ^ inv) && !sy) tag = "R3 random";
      else                  tag = "R6 random";
      chk(tag, {hs_o, ls_o, fault_o}, {e, 1'b0});
    end

    @(posedge clk); #1 rst_ni = 1'b0;
    mon_on = 1'b0;
    settle(2);
    chk("R10 reset mid-run", {hs_o, ls_o, fault_o}, 3'b000);
    finish_run();
  end
endmodule